// File: doc/BRIEF.md
# Event-Driven Multi-Output Match Timer

This block is a free-running up counter that drives a bank of output levels through programmable events. Each event compares the counter against one chosen match register; when it fires, per-output masks decide which outputs it sets high and which it clears low. A per-output resolution code settles what happens when one output receives both a set and a clear on the same count. Typical use is a group of PWM waveforms sharing one period: one event restarts the counter and sets every output, and a second event per output clears it at the duty point.

Software programs the block through a plain write port. Each match register has a shadow reload value that is copied into it whenever the counter returns to zero, so period and duty updates land on a period boundary. A prescaler slows the count, a halt bit freezes everything, and a bidirectional mode makes the counter climb to the limit and then fall back to zero.

Top module: `mt_event_timer`

## Requirements
- R1: After reset all outputs are 0, the counter and prescaler are 0 and halt is 1, so nothing changes until software clears halt.
- R2: The control word carries an 8-bit prescaler value P at bits 12:5; while running, the counter takes one step on every (P+1)-th clock, and P = 0 steps it every clock.
- R3: An event fires on a counter step when its control word has mode 1 at bits 13:12 and the match register chosen by its bits 3:0 equals the counter value before the step; any other mode never fires.
- R4: Output n has a set mask and a clear mask indexed by event number; a step where a firing event hits only the set mask drives the output to 1 one clock later, only the clear mask drives it to 0.
- R5: When set and clear reach output n on the same step, bits 2n+1:2n of the resolution word decide: 0 keep, 1 set, 2 clear, 3 invert.
- R6: The limit mask is indexed by event number; a step where a firing event is in it makes the next counter value 0, so a limit match at N-1 gives a period of N steps.
- R7: On every step whose next counter value is 0, every match register is loaded from its reload register; a direct write to a match register in that cycle wins over the copy.
- R8: While the halt bit (bit 2 of the control word) is 1, counter, prescaler and outputs all hold their values.
- R9: With the bidirectional bit (bit 4 of the control word) set, a limit hit while counting up turns the counter down (next value one less), and reaching 0 while counting down turns it up (next value 1); matches fire in both directions and limit hits while counting down are ignored.
- R10: A write uses address bits 6:4 as the register group (0 control, 1 limit mask, 2 resolution word, 3 match, 4 reload, 5 event control, 6 set mask, 7 clear mask) and bits 3:0 as the index; the written value is in force from the next clock.
- R11: An output whose masks select no firing event keeps its level; an event with empty masks or a zero control word changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Group in bits 6:4, index in bits 3:0 |
| wr_data | input | 32 | Write data |
| out_level | output | 16 | One level per output |

## Verification
A register write lands at the clock edge it is presented on, and its effect on the counter and outputs is first visible one clock after that. An event's result on an output appears at the edge that ends the counting step on which it fired, so outputs lag the counter value that caused them by exactly one clock, and with a prescaler of P a level changes only every P+1 clocks. The bench steps a behavioural model on the same edge as the design, using the inputs held since the previous falling edge, and compares every output on the falling edge that follows, so each result is checked in the very cycle it is due.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int PRE_W          = 8;
    localparam int CTRL_HALT_BIT  = 2;
    localparam int CTRL_BIDIR_BIT = 4;
    localparam int CTRL_PRE_LSB   = 5;
    localparam int EVC_MODE_LSB   = 12;
    localparam int GRP_W          = 3;

    localparam logic [1:0] MODE_MATCH = 2'd1;

    typedef enum logic [GRP_W-1:0] {
        GRP_CTRL    = 3'd0,
        GRP_LIMIT   = 3'd1,
        GRP_RESOLVE = 3'd2,
        GRP_MATCH   = 3'd3,
        GRP_RELOAD  = 3'd4,
        GRP_EVCTRL  = 3'd5,
        GRP_SETMASK = 3'd6,
        GRP_CLRMASK = 3'd7
    } reg_grp_e;

    typedef enum logic [1:0] {
        RES_KEEP   = 2'd0,
        RES_SET    = 2'd1,
        RES_CLEAR  = 2'd2,
        RES_INVERT = 2'd3
    } res_code_e;
endpackage

// File: rtl/mt_step_counter.sv
module mt_step_counter #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             bidir,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             limit_hit,
    output logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        wrap = 1'b0;
        if (!halt) begin
            if (s_q.pre >= pre_val) begin
                tick    = 1'b1;
                s_d.pre = '0;
                if (!bidir) begin
                    s_d.down = 1'b0;
                    s_d.cnt  = limit_hit ? '0 : s_q.cnt + 1'b1;
                end else if (!s_q.down) begin
                    if (limit_hit) begin
                        s_d.down = 1'b1;
                        s_d.cnt  = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end else begin
                    if (s_q.cnt == '0) begin
                        s_d.down = 1'b0;
                        s_d.cnt  = CNT_W'(1);
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                wrap = (s_d.cnt == '0);
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(s_q));

    p_idle_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !tick) |=> $stable(s_q.cnt));

    p_limit_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit_hit && !bidir) |=> (s_q.cnt == '0));

    p_bidir_turn_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && bidir && s_q.down && s_q.cnt == '0) |=> (s_q.cnt == CNT_W'(1) && !s_q.down));
endmodule

// File: rtl/mt_event_match.sv
module mt_event_match #(
    parameter int CNT_W   = 32,
    parameter int N_EVENT = 16,
    parameter int N_MATCH = 16,
    parameter int MSEL_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic [CNT_W-1:0]                count,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   match,
    input  logic [N_EVENT-1:0][MSEL_W-1:0]  ev_sel,
    input  logic [N_EVENT-1:0][1:0]         ev_mode,
    output logic [N_EVENT-1:0]              fire
);
    import mt_pkg::*;

    for (genvar e = 0; e < N_EVENT; e++) begin : g_event
        assign fire[e] = tick && (ev_mode[e] == MODE_MATCH)
                         && (match[ev_sel[e]] == count);
    end

    p_fire_only_on_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> (fire == '0));
endmodule

// File: rtl/mt_output_resolve.sv
module mt_output_resolve #(
    parameter int N_EVENT  = 16,
    parameter int N_OUTPUT = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_EVENT-1:0]                fire,
    input  logic [N_OUTPUT-1:0][N_EVENT-1:0]  set_mask,
    input  logic [N_OUTPUT-1:0][N_EVENT-1:0]  clr_mask,
    input  logic [2*N_OUTPUT-1:0]             resolve,
    output logic [N_OUTPUT-1:0]               level
);
    import mt_pkg::*;

    typedef struct packed {
        logic [N_OUTPUT-1:0] lvl;
    } out_state_t;

    out_state_t o_d, o_q;
    logic [N_OUTPUT-1:0] set_req, clr_req;

    always_comb begin
        o_d = o_q;
        for (int n = 0; n < N_OUTPUT; n++) begin
            set_req[n] = |(fire & set_mask[n]);
            clr_req[n] = |(fire & clr_mask[n]);
            if (set_req[n] && clr_req[n]) begin
                case (res_code_e'(resolve[2*n +: 2]))
                    RES_SET:    o_d.lvl[n] = 1'b1;
                    RES_CLEAR:  o_d.lvl[n] = 1'b0;
                    RES_INVERT: o_d.lvl[n] = ~o_q.lvl[n];
                    default:    o_d.lvl[n] = o_q.lvl[n];
                endcase
            end else if (set_req[n]) begin
                o_d.lvl[n] = 1'b1;
            end else if (clr_req[n]) begin
                o_d.lvl[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign level = o_q.lvl;

    p_single_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((o_q.lvl & $past(set_req & ~clr_req)) == $past(set_req & ~clr_req))
              && ((o_q.lvl & $past(clr_req & ~set_req)) == '0)));

    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((o_q.lvl ^ $past(o_q.lvl)) & ~$past(set_req | clr_req)) == '0));
endmodule

// File: rtl/mt_event_timer.sv
module mt_event_timer #(
    parameter int CNT_W    = 32,
    parameter int N_EVENT  = 16,
    parameter int N_OUTPUT = 16,
    parameter int N_MATCH  = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [mt_pkg::GRP_W+IDX_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [N_OUTPUT-1:0]           out_level
);
    import mt_pkg::*;

    localparam int MSEL_W = $clog2(N_MATCH);

    typedef struct packed {
        logic                            halt;
        logic                            bidir;
        logic [PRE_W-1:0]                pre_val;
        logic [N_EVENT-1:0]              limit;
        logic [2*N_OUTPUT-1:0]           resolve;
        logic [N_MATCH-1:0][CNT_W-1:0]   match;
        logic [N_MATCH-1:0][CNT_W-1:0]   reload;
        logic [N_EVENT-1:0][MSEL_W-1:0]  ev_sel;
        logic [N_EVENT-1:0][1:0]         ev_mode;
        logic [N_OUTPUT-1:0][N_EVENT-1:0] set_mask;
        logic [N_OUTPUT-1:0][N_EVENT-1:0] clr_mask;
    } regs_t;

    regs_t r_d, r_q;

    reg_grp_e         grp;
    logic [IDX_W-1:0] idx;
    logic             tick, wrap, limit_hit;
    logic [CNT_W-1:0] count;
    logic [N_EVENT-1:0] fire;
    logic             unused_wr_bits;

    assign grp            = reg_grp_e'(wr_addr[GRP_W+IDX_W-1:IDX_W]);
    assign idx            = wr_addr[IDX_W-1:0];
    assign unused_wr_bits = ^wr_data;
    assign limit_hit      = |(fire & r_q.limit);

    always_comb begin
        r_d = r_q;
        if (wrap) r_d.match = r_q.reload;
        if (wr_en) begin
            case (grp)
                GRP_CTRL: begin
                    r_d.halt    = wr_data[CTRL_HALT_BIT];
                    r_d.bidir   = wr_data[CTRL_BIDIR_BIT];
                    r_d.pre_val = wr_data[CTRL_PRE_LSB +: PRE_W];
                end
                GRP_LIMIT:   r_d.limit   = wr_data[N_EVENT-1:0];
                GRP_RESOLVE: r_d.resolve = wr_data[2*N_OUTPUT-1:0];
                GRP_MATCH:
                    if (int'(idx) < N_MATCH) r_d.match[idx] = wr_data[CNT_W-1:0];
                GRP_RELOAD:
                    if (int'(idx) < N_MATCH) r_d.reload[idx] = wr_data[CNT_W-1:0];
                GRP_EVCTRL:
                    if (int'(idx) < N_EVENT) begin
                        r_d.ev_sel[idx]  = wr_data[MSEL_W-1:0];
                        r_d.ev_mode[idx] = wr_data[EVC_MODE_LSB +: 2];
                    end
                GRP_SETMASK:
                    if (int'(idx) < N_OUTPUT) r_d.set_mask[idx] = wr_data[N_EVENT-1:0];
                GRP_CLRMASK:
                    if (int'(idx) < N_OUTPUT) r_d.clr_mask[idx] = wr_data[N_EVENT-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.halt <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    mt_step_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (r_q.halt),
        .bidir     (r_q.bidir),
        .pre_val   (r_q.pre_val),
        .limit_hit (limit_hit),
        .tick      (tick),
        .wrap      (wrap),
        .count     (count)
    );

    mt_event_match #(.CNT_W(CNT_W), .N_EVENT(N_EVENT), .N_MATCH(N_MATCH), .MSEL_W(MSEL_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .count   (count),
        .match   (r_q.match),
        .ev_sel  (r_q.ev_sel),
        .ev_mode (r_q.ev_mode),
        .fire    (fire)
    );

    mt_output_resolve #(.N_EVENT(N_EVENT), .N_OUTPUT(N_OUTPUT)) u_outputs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .set_mask (r_q.set_mask),
        .clr_mask (r_q.clr_mask),
        .resolve  (r_q.resolve),
        .level    (out_level)
    );

    p_reload_on_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_en) |=> (r_q.match == $past(r_q.reload)));

    p_limit_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_LIMIT) |=> (r_q.limit == $past(wr_data[N_EVENT-1:0])));

    p_reset_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> r_q.halt);
endmodule

// File: tb/mt_event_timer_test.sv
module mt_event_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] out_level;

    always #5 clk = ~clk;

    mt_event_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_level(out_level)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    checking = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // behavioural reference state
    bit [31:0] m_match [16];
    bit [31:0] m_rel   [16];
    bit [3:0]  m_sel   [16];
    bit [1:0]  m_mode  [16];
    bit [15:0] m_set   [16];
    bit [15:0] m_clr   [16];
    bit [15:0] m_lim;
    bit [31:0] m_res;
    bit        m_halt, m_bidir, m_down;
    int        m_pv, m_pre;
    bit [31:0] m_cnt;
    bit [15:0] m_out;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_match[i] = 0; m_rel[i] = 0; m_sel[i] = 0; m_mode[i] = 0;
            m_set[i] = 0; m_clr[i] = 0;
        end
        m_lim = 0; m_res = 0; m_halt = 1; m_bidir = 0; m_down = 0;
        m_pv = 0; m_pre = 0; m_cnt = 0; m_out = 0;
    endtask

    task automatic model_step();
        bit [15:0] fire;
        bit [15:0] nout;
        bit        hit;
        bit [31:0] nc;
        int        g, ix;
        fire = 0;
        nout = m_out;
        if (!m_halt) begin
            if (m_pre >= m_pv) begin
                m_pre = 0;
                for (int e = 0; e < 16; e++)
                    if (m_mode[e] == 2'd1 && m_match[m_sel[e]] == m_cnt) fire[e] = 1'b1;
                for (int n = 0; n < 16; n++) begin
                    bit s, c;
                    s = (fire & m_set[n]) != 0;
                    c = (fire & m_clr[n]) != 0;
                    if (s && c) begin
                        case ((m_res >> (2 * n)) & 32'd3)
                            32'd1: nout[n] = 1'b1;
                            32'd2: nout[n] = 1'b0;
                            32'd3: nout[n] = ~m_out[n];
                            default: ;
                        endcase
                    end else if (s) nout[n] = 1'b1;
                    else if (c) nout[n] = 1'b0;
                end
                hit = (fire & m_lim) != 0;
                nc = m_cnt;
                if (!m_bidir) begin
                    m_down = 0;
                    nc = hit ? 0 : m_cnt + 1;
                end else if (!m_down) begin
                    if (hit) begin
                        m_down = 1;
                        nc = (m_cnt == 0) ? 0 : m_cnt - 1;
                    end else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_down = 0; nc = 1; end
                    else nc = m_cnt - 1;
                end
                m_cnt = nc;
                if (nc == 0)
                    for (int i = 0; i < 16; i++) m_match[i] = m_rel[i];
            end else begin
                m_pre = (m_pre + 1) % 256;
            end
        end
        m_out = nout;
        if (wr_en) begin
            g  = int'(wr_addr[6:4]);
            ix = int'(wr_addr[3:0]);
            case (g)
                0: begin
                    m_halt  = wr_data[2];
                    m_bidir = wr_data[4];
                    m_pv    = int'(wr_data[12:5]);
                end
                1: m_lim = wr_data[15:0];
                2: m_res = wr_data;
                3: m_match[ix] = wr_data;
                4: m_rel[ix] = wr_data;
                5: begin m_sel[ix] = wr_data[3:0]; m_mode[ix] = wr_data[13:12]; end
                6: m_set[ix] = wr_data[15:0];
                default: m_clr[ix] = wr_data[15:0];
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    always @(negedge clk) begin
        if (rst_n && checking && !done) begin
            n_checks++;
            if (out_level !== m_out) begin
                n_errors++;
                $display("FAIL %s: out_level=%h expected %h at %0t", cur_req, out_level, m_out, $time);
            end
        end
    end

    task automatic wr(input int grp, input int idx, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 7'((grp << 4) | idx);
        wr_data = 32'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic check_now(input string req, input logic [15:0] exp);
        n_checks++;
        if (out_level !== exp) begin
            n_errors++;
            $display("FAIL %s: out_level=%h expected %h", req, out_level, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    localparam int M1 = 1 << 12;
    localparam int M2 = 2 << 12;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, outputs low and timer halted
        check_now("R1", 16'h0000);
        checking = 1'b1;

        // R10: register file programming through the write port, still halted
        cur_req = "R10";
        wr(3, 0, 9);  wr(4, 0, 9);
        wr(3, 1, 3);  wr(4, 1, 3);
        wr(3, 4, 5);  wr(4, 4, 5);
        wr(3, 5, 9);  wr(4, 5, 9);
        wr(5, 0, M1 | 0);
        wr(5, 1, M1 | 1);
        wr(5, 3, M2 | 1);
        wr(5, 4, M1 | 4);
        wr(5, 5, M1 | 5);
        wr(1, 0, 1);
        wr(6, 0, 1);  wr(7, 0, 2);
        wr(6, 1, 1);  wr(7, 1, 1 << 5);
        wr(6, 2, 2);  wr(7, 2, 1);
        wr(6, 3, 1);  wr(7, 3, 1 << 3);
        run(5);
        // R8: halted after reset, nothing may move
        check_now("R8", 16'h0000);

        // R4: basic PWM waveform on outputs 0 and 2
        cur_req = "R4";
        wr(0, 0, 0);
        run(12);
        // R3: mode-2 event on output 3 never clears it
        cur_req = "R3";
        run(12);
        check_now("R3", {12'h000, 1'b1, out_level[2:0]});
        // R6: limit restart gives period 10
        cur_req = "R6";
        run(16);

        // R11: disable the clearing event and rely on empty-mask event 4
        cur_req = "R11";
        wr(5, 1, 0);
        run(25);
        wr(5, 1, M1 | 1);
        run(5);

        // R5: set and clear on output 1 at the same count, all four codes
        cur_req = "R5";
        for (int code = 0; code < 4; code++) begin
            wr(2, 0, code << 2);
            run(25);
        end
        wr(2, 0, 0);

        // R2: prescaler of 3
        cur_req = "R2";
        wr(0, 0, 3 << 5);
        run(70);
        wr(0, 0, 0);
        run(5);

        // R7: reload takes effect at wrap; direct match write reverts at next wrap
        cur_req = "R7";
        wr(4, 1, 6);
        run(30);
        wr(3, 1, 8);
        run(30);
        wr(4, 1, 3);
        run(15);

        // R8: halt mid-run freezes everything, then resumes
        cur_req = "R8";
        wr(0, 0, 4);
        run(15);
        wr(0, 0, 0);
        run(10);

        // R9: bidirectional count, then with prescaler 1
        cur_req = "R9";
        wr(0, 0, 16);
        run(60);
        wr(0, 0, 16 | (1 << 5));
        run(60);
        wr(0, 0, 0);
        run(20);

        checking = 1'b0;
        finish_run();
    end
endmodule